// File: doc/BRIEF.md
# Isochronous Auto-Mode Transmit Packetizer

This block turns a stream of quadlets waiting in a transmit FIFO into fixed-length isochronous packets, at most one per bus cycle. At each cycle-start strobe, while transmission is enabled, it compares the FIFO fill level with the packet size. If enough data is queued, it emits a header quadlet built from configuration inputs and then the payload quadlets. If not, it skips that cycle and pulses a no-transmit interrupt.

The packet size comes in as a byte count. That count goes into the header unchanged. The number of payload quadlets drawn from the FIFO is the byte count rounded up to whole quadlets, and the writer is expected to pad the stream. Transmission is switched on and off by the OR of an external start pin and a software start bit. A rising edge arms transmission from the next cycle start. A falling edge lets exactly one more packet go out, and then transmission stops.

The output is a quadlet stream with a valid/ready handshake and first/last markers. The FIFO is a show-ahead FIFO: its head word is always presented, and a read strobe pops it.

Top module: `iso_tx_packetizer`

## Requirements
- R1: A packet is launched only in the clock cycle after a cycle-start pulse sampled while idle and while transmission is enabled. The header appears on the output with valid and first both set one cycle after that pulse. At most one packet is launched per cycle start.
- R2: The header quadlet is, from bit 31 down to bit 0: byte length[15:0] (the length input, unrounded), tag[1:0], channel[5:0], transaction code[3:0], sync[3:0].
- R3: The payload consists of ceil(length/4) quadlets taken in FIFO order. The last flag is set on the final payload quadlet only. For length 0 the header is sent alone, with both first and last set.
- R4: If the FIFO count is below ceil(length/4) at a cycle start while transmission is enabled, no packet is sent and no_tx_irq_o is high for exactly the one cycle after the strobe. A later cycle start with enough data sends the packet.
- R5: The effective start request is start_pin_i OR start_bit_i. Its 0-to-1 transition enables transmission from the next cycle start onward.
- R6: After a 1-to-0 transition of the effective start request, exactly one further packet is sent. Later cycle starts send nothing and raise no interrupt.
- R7: The sync field is sync_val_i when sync_en_i is 0, and sync_code_i when sync_en_i is 1.
- R8: The channel and tag fields are taken from chan_i and tag_i. The transaction code field is always 4'hA.
- R9: A packet in progress is never cut short. While tx_ready_i is low, the current quadlet and its flags are held. Cycle-start pulses that arrive during a packet are ignored and raise no interrupt.
- R10: fifo_rd_o is high only in a cycle where a payload quadlet is accepted (valid and ready, not the header). Exactly ceil(length/4) quadlets are popped per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | One-cycle cycle-start strobe |
| fifo_count_i | input | CNT_W | Quadlets queued in the transmit FIFO |
| fifo_data_i | input | 32 | Head quadlet of the FIFO (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| len_bytes_i | input | 16 | Packet length in bytes |
| chan_i | input | 6 | Channel number for the header |
| tag_i | input | 2 | Tag field for the header |
| sync_val_i | input | 4 | Fixed sync value |
| sync_en_i | input | 1 | Selects sync_code_i for the sync field |
| sync_code_i | input | 4 | Externally selected sync code |
| start_pin_i | input | 1 | Hardware start request |
| start_bit_i | input | 1 | Software start request |
| tx_data_o | output | 32 | Output quadlet |
| tx_valid_o | output | 1 | Output quadlet valid |
| tx_ready_i | input | 1 | Downstream accepts the quadlet |
| tx_first_o | output | 1 | Quadlet is the header |
| tx_last_o | output | 1 | Quadlet ends the packet |
| no_tx_irq_o | output | 1 | Cycle skipped for lack of data (one-cycle pulse) |

## Verification
A cycle-start pulse is sampled at one rising edge, so the header handshake (R1) and the no-transmit pulse (R4) are both due one cycle after the strobe. The bench checks them at the falling edge right after it lowers the strobe. A start or stop edge on the request takes one register stage, so the bench leaves a full cycle before the next strobe. Payload quadlets depend on the ready handshake. The bench therefore logs every accepted quadlet at falling edges and compares the log, together with the FIFO pop count, only after a settling window that exceeds the packet length plus any stall it applied.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  localparam int unsigned QUAD_W = 32;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned NQ_W   = LEN_W - 1;  // ceil(len/4) fits here
  localparam logic [3:0]  TCODE_ISO = 4'hA;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} seq_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [1:0]       tag;
    logic [5:0]       chan;
    logic [3:0]       tcode;
    logic [3:0]       sy;
  } iso_hdr_t;
endpackage

// File: rtl/iso_tx_start_ctl.sv
module iso_tx_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pin_i,
  input  logic start_bit_i,
  input  logic launch_i,
  output logic run_o
);
  logic req, req_q, rise, fall, fin_q, run_q;

  assign req  = start_pin_i | start_bit_i;
  assign rise = req & ~req_q;
  assign fall = ~req & req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      req_q <= req;
      if (rise) begin
        run_q <= 1'b1;
        fin_q <= 1'b0;
      end else begin
        // the packet launched while stop is pending is the last one
        if (launch_i && fin_q) begin
          run_q <= 1'b0;
          fin_q <= 1'b0;
        end
        if (fall && run_q) fin_q <= 1'b1;
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/iso_tx_hdr_gen.sv
module iso_tx_hdr_gen
  import iso_tx_pkg::*;
(
  input  logic [LEN_W-1:0] len_bytes_i,
  input  logic [5:0]       chan_i,
  input  logic [1:0]       tag_i,
  input  logic [3:0]       sync_val_i,
  input  logic             sync_en_i,
  input  logic [3:0]       sync_code_i,
  output iso_hdr_t         hdr_o,
  output logic [NQ_W-1:0]  nq_o
);
  logic [LEN_W:0] len_up;

  assign len_up = {1'b0, len_bytes_i} + (LEN_W+1)'(3);
  assign nq_o   = len_up[LEN_W:2];

  always_comb begin
    hdr_o.len   = len_bytes_i;
    hdr_o.tag   = tag_i;
    hdr_o.chan  = chan_i;
    hdr_o.tcode = TCODE_ISO;
    hdr_o.sy    = sync_en_i ? sync_code_i : sync_val_i;
  end
endmodule

// File: rtl/iso_tx_seq.sv
module iso_tx_seq
  import iso_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [QUAD_W-1:0] fifo_data_i,
  input  iso_hdr_t          hdr_i,
  input  logic [NQ_W-1:0]   nq_i,
  input  logic              tx_ready_i,
  output logic              fifo_rd_o,
  output logic [QUAD_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_first_o,
  output logic              tx_last_o,
  output logic              launch_o,
  output logic              no_tx_irq_o
);
  localparam int unsigned PAD_W = NQ_W - CNT_W;

  seq_state_e       state_q;
  iso_hdr_t         hdr_q;
  logic [NQ_W-1:0]  rem_q;
  logic             zero_q, irq_q, enough, at_cycle;

  assign enough   = ({{PAD_W{1'b0}}, fifo_count_i} >= nq_i);
  assign at_cycle = (state_q == ST_IDLE) && cyc_start_i && run_i;
  assign launch_o = at_cycle && enough;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      rem_q   <= '0;
      zero_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= at_cycle && !enough;
      unique case (state_q)
        ST_IDLE: if (launch_o) begin
          hdr_q   <= hdr_i;
          rem_q   <= nq_i;
          zero_q  <= (nq_i == '0);
          state_q <= ST_HDR;
        end
        ST_HDR: if (tx_ready_i) state_q <= zero_q ? ST_IDLE : ST_PAY;
        ST_PAY: if (tx_ready_i) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == NQ_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_valid_o = (state_q != ST_IDLE);
    tx_first_o = (state_q == ST_HDR);
    tx_last_o  = (state_q == ST_HDR) ? zero_q : (state_q == ST_PAY) && (rem_q == NQ_W'(1));
    tx_data_o  = (state_q == ST_HDR) ? hdr_q : fifo_data_i;
    fifo_rd_o  = (state_q == ST_PAY) && tx_ready_i;
  end

  assign no_tx_irq_o = irq_q;
endmodule

// File: rtl/iso_tx_packetizer.sv
module iso_tx_packetizer
  import iso_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [31:0]       fifo_data_i,
  output logic              fifo_rd_o,
  input  logic [15:0]       len_bytes_i,
  input  logic [5:0]        chan_i,
  input  logic [1:0]        tag_i,
  input  logic [3:0]        sync_val_i,
  input  logic              sync_en_i,
  input  logic [3:0]        sync_code_i,
  input  logic              start_pin_i,
  input  logic              start_bit_i,
  output logic [31:0]       tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_first_o,
  output logic              tx_last_o,
  output logic              no_tx_irq_o
);
  logic            run, launch;
  iso_hdr_t        hdr;
  logic [NQ_W-1:0] nq;

  iso_tx_start_ctl u_start (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_pin_i (start_pin_i),
    .start_bit_i (start_bit_i),
    .launch_i    (launch),
    .run_o       (run)
  );

  iso_tx_hdr_gen u_hdr (
    .len_bytes_i (len_bytes_i),
    .chan_i      (chan_i),
    .tag_i       (tag_i),
    .sync_val_i  (sync_val_i),
    .sync_en_i   (sync_en_i),
    .sync_code_i (sync_code_i),
    .hdr_o       (hdr),
    .nq_o        (nq)
  );

  iso_tx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_start_i  (cyc_start_i),
    .run_i        (run),
    .fifo_count_i (fifo_count_i),
    .fifo_data_i  (fifo_data_i),
    .hdr_i        (hdr),
    .nq_i         (nq),
    .tx_ready_i   (tx_ready_i),
    .fifo_rd_o    (fifo_rd_o),
    .tx_data_o    (tx_data_o),
    .tx_valid_o   (tx_valid_o),
    .tx_first_o   (tx_first_o),
    .tx_last_o    (tx_last_o),
    .launch_o     (launch),
    .no_tx_irq_o  (no_tx_irq_o)
  );
endmodule

// File: rtl/iso_tx_chk.sv
module iso_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_start_i,
  input logic        fifo_rd_o,
  input logic [31:0] tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic        tx_first_o,
  input logic        tx_last_o,
  input logic        no_tx_irq_o
);
  a_r1_launch_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(cyc_start_i) && tx_first_o);

  a_r3_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);

  a_r4_irq_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_tx_irq_o |-> $past(cyc_start_i) && !tx_valid_o);

  a_r8_tcode_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_first_o |-> tx_data_o[7:4] == 4'hA);

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_first_o) && $stable(tx_last_o));

  a_r9_header_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_first_o && !tx_ready_i |=> $stable(tx_data_o));

  a_r10_pop_on_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> tx_valid_o && tx_ready_i && !tx_first_o);
endmodule

bind iso_tx_packetizer iso_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .fifo_rd_o   (fifo_rd_o),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_first_o  (tx_first_o),
  .tx_last_o   (tx_last_o),
  .no_tx_irq_o (no_tx_irq_o)
);

// File: tb/sim_iso_tx_packetizer.sv
`timescale 1ns/1ps
module sim_iso_tx_packetizer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cyc = 1'b0, pin = 1'b0, sbit = 1'b0, ready = 1'b1, sync_en = 1'b0;
  logic [15:0] len = '0;
  logic [5:0]  chan = '0;
  logic [1:0]  tag = '0;
  logic [3:0]  sync_val = '0, sync_code = '0;
  logic [11:0] fifo_count;
  logic [31:0] fifo_data, tx_data;
  logic        fifo_rd, tx_valid, tx_first, tx_last, irq;

  logic [31:0] fmem [256];
  int unsigned wr_p = 0, rd_p = 0;
  logic [31:0] cap_d [512];
  logic        cap_f [512], cap_l [512];
  int unsigned cap_n = 0, irq_cnt = 0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign fifo_count = 12'(wr_p - rd_p);
  assign fifo_data  = fmem[rd_p % 256];

  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  always @(negedge clk) begin
    if (tx_valid && ready) begin
      cap_d[cap_n % 512] <= tx_data;
      cap_f[cap_n % 512] <= tx_first;
      cap_l[cap_n % 512] <= tx_last;
      cap_n <= cap_n + 1;
    end
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  iso_tx_packetizer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc),
    .fifo_count_i(fifo_count), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .len_bytes_i(len), .chan_i(chan), .tag_i(tag), .sync_val_i(sync_val),
    .sync_en_i(sync_en), .sync_code_i(sync_code),
    .start_pin_i(pin), .start_bit_i(sbit),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(ready),
    .tx_first_o(tx_first), .tx_last_o(tx_last), .no_tx_irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic [15:0] l, input logic [1:0] t,
                                          input logic [5:0] c, input logic [3:0] s);
    return {l, t, c, 4'hA, s};
  endfunction

  task automatic push(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      fmem[wr_p % 256] = seed + 32'(i);
      wr_p++;
    end
  endtask

  task automatic run_cyc();
    @(negedge clk) cyc = 1'b1;
    @(negedge clk) cyc = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // checks one logged packet starting at base
  task automatic expect_pkt(input string req, input int unsigned base, input logic [31:0] hdr,
                            input int nq, input logic [31:0] seed);
    check(cap_n - base == 32'(nq + 1), req, cap_n - base, 32'(nq + 1));
    check(cap_d[base % 512] == hdr && cap_f[base % 512], req, cap_d[base % 512], hdr);
    check(cap_l[base % 512] == (nq == 0), {req, " hdr last"}, 32'(cap_l[base % 512]), 32'(nq == 0));
    for (int i = 1; i <= nq; i++) begin
      int unsigned k = (base + i) % 512;
      check(cap_d[k] == seed + 32'(i - 1) && !cap_f[k] && cap_l[k] == (i == nq),
            {req, " payload"}, cap_d[k], seed + 32'(i - 1));
    end
  endtask

  task automatic t_reset();
    check(!tx_valid && !fifo_rd && !irq, "R1 reset", {29'b0, tx_valid, fifo_rd, irq}, 32'h0);
    push(1, 32'h0);
    run_cyc();
    check(!tx_valid && !irq, "R1 no run no launch", {30'b0, tx_valid, irq}, 32'h0);
    rd_p = wr_p;
  endtask

  task automatic t_basic();
    int unsigned base, r0;
    len = 16'd12; chan = 6'd5; tag = 2'd1; sync_val = 4'd3; sync_en = 1'b0;
    push(3, 32'h1000);
    @(negedge clk) pin = 1'b1;
    idle(1);
    base = cap_n; r0 = rd_p;
    run_cyc();
    check(tx_valid && tx_first, "R1 header due one cycle after strobe (R5 start)",
          {30'b0, tx_valid, tx_first}, 32'h3);
    idle(10);
    expect_pkt("R2 R8 R7 basic", base, mk_hdr(16'd12, 2'd1, 6'd5, 4'd3), 3, 32'h1000);
    check(rd_p - r0 == 3, "R10 pop count", rd_p - r0, 32'd3);
  endtask

  task automatic t_round();
    int unsigned base;
    len = 16'd5; chan = 6'd63; tag = 2'd2;
    push(2, 32'h2000);
    base = cap_n; run_cyc(); idle(8);
    expect_pkt("R3 len 5", base, mk_hdr(16'd5, 2'd2, 6'd63, 4'd3), 2, 32'h2000);
    len = 16'd13;
    push(4, 32'h3000);
    base = cap_n; run_cyc(); idle(10);
    expect_pkt("R3 len 13", base, mk_hdr(16'd13, 2'd2, 6'd63, 4'd3), 4, 32'h3000);
    len = 16'd0;
    base = cap_n; run_cyc(); idle(4);
    expect_pkt("R3 len 0", base, mk_hdr(16'd0, 2'd2, 6'd63, 4'd3), 0, 32'h0);
  endtask

  task automatic t_short();
    int unsigned base;
    len = 16'd16; chan = 6'd9; tag = 2'd0;
    push(2, 32'h4000);
    base = cap_n;
    run_cyc();
    check(irq && !tx_valid, "R4 skip and irq", {30'b0, irq, tx_valid}, 32'h2);
    idle(1);
    check(!irq, "R4 irq one cycle", 32'(irq), 32'h0);
    idle(4);
    check(cap_n == base, "R4 nothing sent", cap_n - base, 32'd0);
    push(2, 32'h4002);
    run_cyc(); idle(10);
    expect_pkt("R4 retry", base, mk_hdr(16'd16, 2'd0, 6'd9, 4'd3), 4, 32'h4000);
  endtask

  task automatic t_sync();
    int unsigned base;
    len = 16'd4; sync_en = 1'b1; sync_code = 4'd9; sync_val = 4'd3;
    push(1, 32'h5000);
    base = cap_n; run_cyc(); idle(5);
    expect_pkt("R7 sync code", base, mk_hdr(16'd4, 2'd0, 6'd9, 4'd9), 1, 32'h5000);
    sync_en = 1'b0;
  endtask

  task automatic t_stall();
    int unsigned base, i0;
    len = 16'd16;
    push(4, 32'h6000);
    base = cap_n; i0 = irq_cnt;
    @(negedge clk) ready = 1'b0;
    run_cyc();
    idle(3);
    check(tx_valid && tx_first && tx_data == mk_hdr(16'd16, 2'd0, 6'd9, 4'd3),
          "R9 header held", tx_data, mk_hdr(16'd16, 2'd0, 6'd9, 4'd3));
    ready = 1'b1;
    idle(2);
    ready = 1'b0;
    cyc = 1'b1;
    idle(1);
    cyc = 1'b0;
    idle(3);
    check(tx_valid && !tx_first && !tx_last, "R9 payload held", {30'b0, tx_valid, tx_last}, 32'h2);
    ready = 1'b1;
    idle(10);
    expect_pkt("R9 stalled packet", base, mk_hdr(16'd16, 2'd0, 6'd9, 4'd3), 4, 32'h6000);
    check(irq_cnt == i0, "R9 mid-packet strobe ignored", irq_cnt - i0, 32'd0);
  endtask

  task automatic t_stop();
    int unsigned base, i0;
    len = 16'd4;
    @(negedge clk) pin = 1'b0;
    idle(1);
    push(1, 32'h7000);
    base = cap_n; run_cyc(); idle(5);
    expect_pkt("R6 final packet", base, mk_hdr(16'd4, 2'd0, 6'd9, 4'd3), 1, 32'h7000);
    push(1, 32'h7100);
    base = cap_n; i0 = irq_cnt;
    run_cyc(); idle(5);
    check(cap_n == base && irq_cnt == i0, "R6 stopped", cap_n - base, 32'd0);
    @(negedge clk) sbit = 1'b1;
    idle(1);
    base = cap_n; run_cyc(); idle(5);
    expect_pkt("R5 software start", base, mk_hdr(16'd4, 2'd0, 6'd9, 4'd3), 1, 32'h7100);
    @(negedge clk) sbit = 1'b0;
    idle(1);
    push(2, 32'h7200);
    base = cap_n; run_cyc(); idle(5);
    run_cyc(); idle(5);
    check(cap_n - base == 2, "R6 one packet after software stop", cap_n - base, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_round();
    t_short();
    t_sync();
    t_stall();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule